// File: doc/BRIEF.md
# Clock Output Configuration Register Bank

This block holds the settings for eight clock output channels, one configuration word per channel. Each word selects the channel's output mode, sets its divider code, sets a delay code and turns the output on or off. A write stream carries an address and a 16-bit data word. The accepted word goes into the channel register that the address selects. All channel settings are always present as parallel outputs for the channel logic. The block also derives, for each channel, whether the divider and delay stages are in the path, the divide ratio that results, and a flag for a divider code that is not allowed.

Channel 0's word has one extra bit. When that bit is set, it returns the whole bank to its power-on settings. In that case the rest of the word is thrown away. The bit is a one-shot command and is never stored. Channel 0 then has to be written again, with the bit clear, before it takes real settings. The write interface is valid/ready. Ready is low while the asynchronous reset is applied and goes high on the first clock edge after reset is released. It then stays high, so the block never applies back-pressure. A word is taken on any rising edge where valid and ready are both high. Valid may drop at any time, and the address and data matter only on an accepted edge.

Top module: `clkout_cfg_bank`

## Requirements
- R1: While rst_n is low, and after it is released until the first write, every channel reads mode 0 (bypass), divider code 1, delay code 0, enable 0, effective ratio 1, and no error.
- R2: An accepted write to address N with bit 15 clear stores data bits [1:0] as mode, [9:2] as divider code, [13:10] as delay code and [14] as enable into channel N. The new values appear after that rising edge. No other channel changes.
- R3: An accepted write to address 0 with bit 15 set puts all eight channels back to the R1 values after that edge. None of that word's other bits are stored.
- R4: On addresses 1 to 7, bit 15 has no special meaning. The word is stored as in R2 and no other channel changes.
- R5: wr_ready is low during reset and high from the first rising edge after reset is released. When wr_valid is low, no channel changes, whatever the address and data.
- R6: A channel's divider is active for modes 1 (divided) and 3 (divided and delayed). Its delay is active for modes 2 (delayed) and 3.
- R7: The effective divide ratio is twice the divider code when the divider is active. Otherwise it is 1.
- R8: The error flag is high exactly when the divider is active and the divider code is 0.
- R9: The bank-reset bit is not remembered. A following write to address 0 with bit 15 clear stores its fields normally and does not reset the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Bank can accept a write |
| wr_addr | input | 3 | Channel index of the write |
| wr_data | input | 16 | Configuration word |
| ch_mode | output | 16 | Mode of each channel, 2 bits per channel, channel 0 lowest |
| ch_div_code | output | 64 | Divider code of each channel, 8 bits per channel |
| ch_delay | output | 32 | Delay code of each channel, 4 bits per channel |
| ch_enable | output | 8 | Output enable of each channel |
| ch_div_active | output | 8 | Divider in the path for each channel |
| ch_dly_active | output | 8 | Delay stage in the path for each channel |
| ch_ratio | output | 72 | Effective divide ratio of each channel, 9 bits per channel |
| ch_cfg_err | output | 8 | Divider active with code 0, for each channel |

## Verification
The bench sweeps every mode against every divider code on one channel. A mix-up in the mode decode, or a ratio that is not doubled or is not forced to 1 in bypass, would show up in that sweep, and so would a missing error flag for code 0. The bank-reset bit is exercised three ways. It is set together with non-default fields in channel 0, and a design that stored those fields would show them. It is set on a non-zero address, where a design that decoded it without checking the address would wipe the bank. It is followed by a plain channel-0 write, which catches a design that latched the bit. Writes offered with valid low check that the bank is not loaded by the strobe alone. After every step the bench compares all eight channels, so a decode that spills a write into a neighbouring channel is caught.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NUM_CH  = 8;
  localparam int MODE_W  = 2;
  localparam int CODE_W  = 8;
  localparam int DLY_W   = 4;
  localparam int CFG_W   = MODE_W + CODE_W + DLY_W + 1;
  localparam int WORD_W  = CFG_W + 1;
  localparam int CLR_BIT = WORD_W - 1;
  localparam int RATIO_W = CODE_W + 1;

  typedef enum logic [MODE_W-1:0] {
    MODE_BYPASS  = 2'd0,
    MODE_DIV     = 2'd1,
    MODE_DLY     = 2'd2,
    MODE_DIV_DLY = 2'd3
  } mode_e;

  // packed order puts mode in the low bits, enable on top
  typedef struct packed {
    logic             en;
    logic [DLY_W-1:0] dly;
    logic [CODE_W-1:0] code;
    mode_e            mode;
  } chan_cfg_t;

  function automatic chan_cfg_t cfg_default();
    chan_cfg_t c;
    c.en   = 1'b0;
    c.dly  = '0;
    c.code = CODE_W'(1);
    c.mode = MODE_BYPASS;
    return c;
  endfunction
endpackage

// File: rtl/clkcfg_wr_decode.sv
module clkcfg_wr_decode
  import clkcfg_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int ADDR_W = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] data,
  output logic [N_CH-1:0]   load_vec,
  output logic              bank_clr,
  output chan_cfg_t         wcfg
);
  logic clr_req;

  assign wcfg     = chan_cfg_t'(data[CFG_W-1:0]);
  assign clr_req  = data[CLR_BIT] && (addr == '0);
  assign bank_clr = fire && clr_req;

  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    assign load_vec[i] = fire && !clr_req && (addr == ADDR_W'(i));
  end

  // R2: a write reaches at most one channel
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec));
  // R3: a bank clear never also loads a channel
  a_r3_clear_excludes_load: assert property (@(posedge clk) disable iff (!rst_n)
    bank_clr |-> (load_vec == '0));
  // R4: the clear bit on a nonzero address still loads that channel
  a_r4_high_addr_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && addr != '0) |-> $countones(load_vec) == 1);
endmodule

// File: rtl/clkcfg_chan_reg.sv
module clkcfg_chan_reg
  import clkcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               clr,
  input  chan_cfg_t          wcfg,
  output chan_cfg_t          cfg,
  output logic               div_active,
  output logic               dly_active,
  output logic [RATIO_W-1:0] ratio,
  output logic               cfg_err
);
  chan_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= cfg_default();
    else if (clr)    cfg_q <= cfg_default();
    else if (load)   cfg_q <= wcfg;
  end

  assign cfg = cfg_q;

  always_comb begin
    div_active = 1'b0;
    dly_active = 1'b0;
    case (cfg_q.mode)
      MODE_DIV:     div_active = 1'b1;
      MODE_DLY:     dly_active = 1'b1;
      MODE_DIV_DLY: begin div_active = 1'b1; dly_active = 1'b1; end
      default: ;
    endcase
  end

  assign ratio   = div_active ? {cfg_q.code, 1'b0} : RATIO_W'(1);
  assign cfg_err = div_active && (cfg_q.code == '0);

  // R3: a bank clear lands the defaults on the next edge
  a_r3_clear_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cfg == cfg_default()));
  // R2: a load stores the offered word
  a_r2_load_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cfg == $past(wcfg)));
  // R5: without load or clear the channel holds
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable(cfg));
  // R8: an error implies the divider is in the path
  a_r8_err_needs_div: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (div_active && ratio == '0));
endmodule

// File: rtl/clkout_cfg_bank.sv
module clkout_cfg_bank
  import clkcfg_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int ADDR_W = $clog2(N_CH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  output logic                      wr_ready,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [N_CH*MODE_W-1:0]    ch_mode,
  output logic [N_CH*CODE_W-1:0]    ch_div_code,
  output logic [N_CH*DLY_W-1:0]     ch_delay,
  output logic [N_CH-1:0]           ch_enable,
  output logic [N_CH-1:0]           ch_div_active,
  output logic [N_CH-1:0]           ch_dly_active,
  output logic [N_CH*RATIO_W-1:0]   ch_ratio,
  output logic [N_CH-1:0]           ch_cfg_err
);
  logic            ready_q;
  logic            fire;
  logic [N_CH-1:0] load_vec;
  logic            bank_clr;
  chan_cfg_t       wcfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign wr_ready = ready_q;
  assign fire     = wr_valid && ready_q;

  clkcfg_wr_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .addr     (wr_addr),
    .data     (wr_data),
    .load_vec (load_vec),
    .bank_clr (bank_clr),
    .wcfg     (wcfg)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    chan_cfg_t cfg_i;
    clkcfg_chan_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_vec[i]),
      .clr        (bank_clr),
      .wcfg       (wcfg),
      .cfg        (cfg_i),
      .div_active (ch_div_active[i]),
      .dly_active (ch_dly_active[i]),
      .ratio      (ch_ratio[i*RATIO_W +: RATIO_W]),
      .cfg_err    (ch_cfg_err[i])
    );
    assign ch_mode[i*MODE_W +: MODE_W]     = cfg_i.mode;
    assign ch_div_code[i*CODE_W +: CODE_W] = cfg_i.code;
    assign ch_delay[i*DLY_W +: DLY_W]      = cfg_i.dly;
    assign ch_enable[i]                    = cfg_i.en;
  end

  // R5: ready rises one edge after reset release and then stays high
  a_r5_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> wr_ready);
  // R9: a plain channel-0 write leaves channel 1 alone
  a_r9_no_latched_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_addr == '0 && !wr_data[CLR_BIT])
      |=> $stable(ch_mode[MODE_W +: MODE_W]));
endmodule

// File: tb/sim_clkout_cfg_bank.sv
module sim_clkout_cfg_bank;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] ch_mode;
  logic [63:0] ch_div_code;
  logic [31:0] ch_delay;
  logic [7:0]  ch_enable, ch_div_active, ch_dly_active, ch_cfg_err;
  logic [71:0] ch_ratio;

  int checks = 0;
  int fails  = 0;
  logic [1:0] m_mode [N];
  logic [7:0] m_code [N];
  logic [3:0] m_dly  [N];
  logic       m_en   [N];

  always #2.5 clk = ~clk;

  clkout_cfg_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ch_mode(ch_mode),
    .ch_div_code(ch_div_code), .ch_delay(ch_delay), .ch_enable(ch_enable),
    .ch_div_active(ch_div_active), .ch_dly_active(ch_dly_active),
    .ch_ratio(ch_ratio), .ch_cfg_err(ch_cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_defaults();
    for (int i = 0; i < N; i++) begin
      m_mode[i] = 2'd0; m_code[i] = 8'd1; m_dly[i] = 4'd0; m_en[i] = 1'b0;
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      logic da, ya;
      int   rat;
      da  = m_mode[i][0];
      ya  = m_mode[i][1];
      rat = da ? 2 * int'(m_code[i]) : 1;
      chk({req, " mode"},  int'(ch_mode[i*2 +: 2]),     int'(m_mode[i]));
      chk({req, " code"},  int'(ch_div_code[i*8 +: 8]), int'(m_code[i]));
      chk({req, " delay"}, int'(ch_delay[i*4 +: 4]),    int'(m_dly[i]));
      chk({req, " en"},    int'(ch_enable[i]),          int'(m_en[i]));
      chk("R6 div_active", int'(ch_div_active[i]), int'(da));
      chk("R6 dly_active", int'(ch_dly_active[i]), int'(ya));
      chk("R7 ratio",      int'(ch_ratio[i*9 +: 9]), rat);
      chk("R8 cfg_err",    int'(ch_cfg_err[i]), int'(da && m_code[i] == 8'd0));
    end
  endtask

  function automatic logic [15:0] word(input logic clr, input logic en,
      input logic [3:0] d, input logic [7:0] c, input logic [1:0] m);
    return {clr, en, d, c, m};
  endfunction

  // drives one cycle then samples at the following negedge
  task automatic wr(input logic v, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    if (v) begin
      if (a == 3'd0 && d[15]) model_defaults();
      else begin
        m_mode[a] = d[1:0]; m_code[a] = d[9:2]; m_dly[a] = d[13:10]; m_en[a] = d[14];
      end
    end
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_defaults();
    #12;
    chk("R5 ready in reset", int'(wr_ready), 0);
    check_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R5 ready after reset", int'(wr_ready), 1);
    check_all("R1 after release");

    // R2: distinct word per channel
    for (int i = 0; i < N; i++)
      wr(1'b1, 3'(i), word(1'b0, i[0], 4'(i + 3), 8'(17 * i + 5), 2'(i)));
    check_all("R2 per channel");

    // R5: valid low, nothing stored
    wr(1'b0, 3'd4, word(1'b0, 1'b1, 4'hF, 8'hAA, 2'd3));
    wr(1'b0, 3'd0, 16'h8000);
    check_all("R5 valid low");

    // R6 R7 R8: every mode with every code on channel 5
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 256; c++) begin
        wr(1'b1, 3'd5, word(1'b0, 1'b1, 4'(c), 8'(c), 2'(m)));
        check_all("R2 sweep");
      end

    // R2: delay and enable sweep on channel 2
    for (int d = 0; d < 32; d++) begin
      wr(1'b1, 3'd2, word(1'b0, d[4], d[3:0], 8'd9, 2'd2));
      check_all("R2 delay en");
    end

    // R4: clear bit on addresses 1..7 is plain data
    for (int a = 1; a < N; a++) begin
      wr(1'b1, 3'(a), word(1'b1, 1'b1, 4'd7, 8'(a * 3), 2'd1));
      check_all("R4 high addr");
    end

    // R3: bank clear, other bits of the word discarded
    wr(1'b1, 3'd0, word(1'b0, 1'b1, 4'd6, 8'd40, 2'd3));
    wr(1'b1, 3'd0, word(1'b1, 1'b1, 4'd9, 8'd77, 2'd1));
    check_all("R3 bank clear");

    // R9: rewrite channel 0 with the bit clear
    wr(1'b1, 3'd1, word(1'b0, 1'b1, 4'd2, 8'd12, 2'd2));
    wr(1'b1, 3'd0, word(1'b0, 1'b1, 4'd5, 8'd33, 2'd1));
    check_all("R9 rewrite ch0");
    wr(1'b1, 3'd0, word(1'b0, 1'b0, 4'd1, 8'd0, 2'd3));
    check_all("R9 second write");

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    model_defaults();
    check_all("R1 async reset");
    chk("R5 ready drops", int'(wr_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after second release");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule